// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single register accesses into timed bus cycles on an 8-bit raw NAND flash device. Writing the command register runs a latch cycle with the command-latch line high. Writing the address register runs the same kind of cycle with the address-latch line high. Writing the data register runs a plain data write cycle. Reading the data register runs a read-strobe cycle and returns the byte the device drove onto the bus.

Every cycle has four phases in a fixed order: setup, strobe low, strobe high (hold), and an optional ready wait. The length of each phase comes from a packed 32-bit timing word, counted in controller clocks. Read cycles and write cycles take their lengths from separate halves of that word. A configuration bit holds chip enable low for as long as it is set. A status bit reports the device ready line.

The register port has no handshake apart from a stall signal. An access is held on the port until `reg_wait` is low at a rising clock edge, and it completes at that edge.

Top module: `nandbus_seq`

## Requirements
- R1: After reset the chip-enable output is high (inactive), both latch lines are low, both strobes are high and the bus driver is off. The configuration and timing registers read as 0.
- R2: A write to byte offset 0x08 runs a write-strobe cycle. The command-latch line is high and the address-latch line is low through setup, strobe and hold. The bus carries write data bits [7:0] with its driver enabled.
- R3: A write to byte offset 0x04 runs the same cycle as R2, except that the address-latch line is the one held high.
- R4: A write to byte offset 0x00 runs a write-strobe cycle with both latch lines low. A read of byte offset 0x00 runs a read-strobe cycle with the driver off. The byte sampled on the last clock of the strobe-low phase is returned in bits [7:0], with bits [31:8] zero.
- R5: The timing word at byte offset 0x2C holds eight 4-bit fields. Bits [3:0], [7:4], [11:8] and [15:12] are the read setup, hold, width and ready delay. Bits [19:16], [23:20], [27:24] and [31:28] are the same four for writes. A setup, width or hold value N lasts N+1 clocks. Command, address and data writes use the write fields; data reads use the read fields.
- R6: A ready-delay value N adds 2*N clocks after the hold phase before the cycle ends. A value of 0 adds none.
- R7: Bit 5 of the configuration register (byte offset 0x14) drives chip enable low while it is 1 and releases it high when it is 0. The bit reads back at the same position.
- R8: Bit 0 of the status register (byte offset 0x18) shows the device ready line as registered one clock earlier. All other status bits read 0.
- R9: After a command or address cycle, the next data cycle does not start its setup phase until the ready line is seen high.
- R10: `reg_wait` is high from the clock an access that needs a bus cycle is presented until its cycle has finished all phases. The access completes on the first following edge. Register-only accesses complete without waiting when the sequencer is idle.
- R11: Writing 1 to bit 2 of the control register (byte offset 0x10) returns the configuration and timing registers to 0, idles the sequencer and drops any pending wait for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Byte offset of the register being accessed |
| reg_wr | input | 1 | Write request, held until accepted |
| reg_rd | input | 1 | Read request, held until accepted |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when `reg_wait` is low |
| reg_wait | output | 1 | Stall: the access does not complete at this edge |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven toward the device |
| nand_io_oe | output | 1 | Output enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte driven by the device |
| nand_rdy | input | 1 | Device ready (1) / busy (0) |

## Verification
Two events can land on the same clock edge: the ready line rising, and a data request that has been held behind an earlier command cycle. The bench holds a data write pending with ready low and confirms that neither strobe moves for several clocks. It then raises ready and checks that exactly one strobe-low clock follows.

Every table-driven cycle is measured per phase at falling edges. The expected setup, strobe, hold-plus-delay and total stall counts are worked out from the timing word by the bench's own field arithmetic. For read cycles, the bench presents the wanted byte only on the final strobe-low clock and its complement on every other clock, so a sample taken one clock early or late shows up as a wrong return value.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int FLD_W = 4;
  localparam int TIM_W = 8 * FLD_W;

  typedef enum logic [1:0] {K_CMD, K_ADR, K_DWR, K_DRD} kind_e;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RWAIT} phase_e;

  typedef struct packed {
    logic [FLD_W-1:0] setup;
    logic [FLD_W-1:0] width;
    logic [FLD_W-1:0] hold;
    logic [FLD_W-1:0] rdly;
  } tim_t;

  // ready wait of 2*n clocks: counter load is 2*n-1 (n must be non-zero)
  function automatic logic [FLD_W+1:0] rwait_load(logic [FLD_W-1:0] n);
    return {1'b0, n, 1'b0} - 1'b1;
  endfunction

  function automatic logic is_latch(kind_e k);
    return (k == K_CMD) || (k == K_ADR);
  endfunction
endpackage

// File: rtl/nseq_tim_dec.sv
module nseq_tim_dec
  import nseq_pkg::*;
(
  input  logic [TIM_W-1:0] word,
  input  logic             rd_sel,
  output tim_t             fld
);
  localparam int HALF_W = 4 * FLD_W;

  logic [HALF_W-1:0] half;
  assign half = rd_sel ? word[HALF_W-1:0] : word[2*HALF_W-1:HALF_W];

  assign fld.setup = half[0       +: FLD_W];
  assign fld.hold  = half[FLD_W   +: FLD_W];
  assign fld.width = half[2*FLD_W +: FLD_W];
  assign fld.rdly  = half[3*FLD_W +: FLD_W];
endmodule

// File: rtl/nseq_engine.sv
module nseq_engine
  import nseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sreset,
  input  logic              launch,
  input  kind_e             kind_in,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [TIM_W-1:0]  tim_word,
  output phase_e            phase,
  output kind_e             kind,
  output logic [DATA_W-1:0] byte_q,
  output logic              done,
  output logic              capture
);
  localparam int CNT_W = FLD_W + 2;

  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             rd_sel;
  tim_t             fld;

  assign rd_sel = (phase == PH_IDLE) ? (kind_in == K_DRD) : (kind == K_DRD);

  nseq_tim_dec u_dec (.word(tim_word), .rd_sel(rd_sel), .fld(fld));

  assign last    = (cnt == '0);
  assign done    = last && (((phase == PH_HOLD) && (fld.rdly == '0)) || (phase == PH_RWAIT));
  assign capture = last && (phase == PH_STROBE) && (kind == K_DRD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      kind   <= K_CMD;
      byte_q <= '0;
    end else if (sreset) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      kind   <= K_CMD;
      byte_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (launch) begin
          phase  <= PH_SETUP;
          cnt    <= CNT_W'(fld.setup);
          kind   <= kind_in;
          byte_q <= byte_in;
        end
        PH_SETUP: if (last) begin
          phase <= PH_STROBE;
          cnt   <= CNT_W'(fld.width);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (last) begin
          phase <= PH_HOLD;
          cnt   <= CNT_W'(fld.hold);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (last) begin
          if (fld.rdly == '0) phase <= PH_IDLE;
          else begin
            phase <= PH_RWAIT;
            cnt   <= rwait_load(fld.rdly);
          end
        end else cnt <= cnt - 1'b1;
        PH_RWAIT: if (last) phase <= PH_IDLE;
        else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: the ready wait only ever follows the hold phase or itself
  a_r6_rwait_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RWAIT) |-> ($past(phase) == PH_HOLD || $past(phase) == PH_RWAIT));
  // R5: strobe is always entered from setup
  a_r5_strobe_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> $past(phase) == PH_SETUP);
  // R10: a finished cycle returns to idle at once
  a_r10_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sreset) |=> phase == PH_IDLE);
endmodule

// File: rtl/nandbus_seq.sv
module nandbus_seq
  import nseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int REG_W  = 32,
  parameter int CE_BIT = 5,
  parameter int SR_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_wait,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [DATA_W-1:0] nand_io_in,
  input  logic              nand_rdy
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] OFS_ADR  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(6'h14);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(6'h18);
  localparam logic [ADDR_W-1:0] OFS_TIM  = ADDR_W'(6'h2C);

  // register state
  logic              cfg_ce;
  logic [TIM_W-1:0]  tim_q;
  logic              rdy_q;
  logic              need_rdy;
  logic              served;
  logic [DATA_W-1:0] rd_byte;

  // decoded request
  logic  req, is_bus, is_data, gated, launch, acc_fire, srst_fire;
  kind_e req_kind;

  // engine side
  phase_e            phase;
  kind_e             eng_kind;
  logic [DATA_W-1:0] eng_byte;
  logic              eng_done, eng_capture, eng_idle, active;

  assign req = reg_wr | reg_rd;

  always_comb begin
    is_bus   = 1'b0;
    req_kind = K_CMD;
    if (reg_wr && reg_addr == OFS_CMD) begin
      is_bus = 1'b1; req_kind = K_CMD;
    end else if (reg_wr && reg_addr == OFS_ADR) begin
      is_bus = 1'b1; req_kind = K_ADR;
    end else if (reg_addr == OFS_DATA && req) begin
      is_bus = 1'b1; req_kind = reg_wr ? K_DWR : K_DRD;
    end
  end

  assign is_data   = is_bus && !is_latch(req_kind);
  assign eng_idle  = (phase == PH_IDLE);
  assign gated     = is_data && need_rdy && !rdy_q;
  assign launch    = req && is_bus && eng_idle && !served && !gated;
  assign reg_wait  = req && (!eng_idle || (is_bus && !served));
  assign acc_fire  = req && !reg_wait;
  assign srst_fire = acc_fire && reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[SR_BIT];

  nseq_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sreset   (srst_fire),
    .launch   (launch),
    .kind_in  (req_kind),
    .byte_in  (reg_wdata[DATA_W-1:0]),
    .tim_word (tim_q),
    .phase    (phase),
    .kind     (eng_kind),
    .byte_q   (eng_byte),
    .done     (eng_done),
    .capture  (eng_capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ce   <= 1'b0;
      tim_q    <= '0;
      rdy_q    <= 1'b0;
      need_rdy <= 1'b0;
      served   <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rdy_q <= nand_rdy;
      if (eng_capture) rd_byte <= nand_io_in;
      if (srst_fire) begin
        cfg_ce   <= 1'b0;
        tim_q    <= '0;
        need_rdy <= 1'b0;
        served   <= 1'b0;
      end else begin
        if (acc_fire && reg_wr && reg_addr == OFS_CFG) cfg_ce <= reg_wdata[CE_BIT];
        if (acc_fire && reg_wr && reg_addr == OFS_TIM) tim_q <= reg_wdata[TIM_W-1:0];
        if (eng_done) served <= 1'b1;
        else if (acc_fire) served <= 1'b0;
        if (eng_done && is_latch(eng_kind)) need_rdy <= 1'b1;
        else if (launch && is_data) need_rdy <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_DATA: reg_rdata[DATA_W-1:0] = rd_byte;
      OFS_CFG:  reg_rdata[CE_BIT]     = cfg_ce;
      OFS_STAT: reg_rdata[0]          = rdy_q;
      OFS_TIM:  reg_rdata[TIM_W-1:0]  = tim_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign active      = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign nand_ce_n   = !cfg_ce;
  assign nand_cle    = active && (eng_kind == K_CMD);
  assign nand_ale    = active && (eng_kind == K_ADR);
  assign nand_we_n   = !((phase == PH_STROBE) && (eng_kind != K_DRD));
  assign nand_re_n   = !((phase == PH_STROBE) && (eng_kind == K_DRD));
  assign nand_io_oe  = active && (eng_kind != K_DRD);
  assign nand_io_out = eng_byte;

  // R2 / R3: the two latch lines are never high together
  a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R4: only one strobe at a time
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R4: a write strobe always has the bus driven
  a_r4_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_io_oe);
  // R10: any held access stalls while the engine is busy
  a_r10_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !eng_idle) |-> reg_wait);
  // R9: a data cycle never begins its setup while ready was seen low after a latch cycle
  a_r9_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP && $past(phase) == PH_IDLE && eng_kind != K_CMD && eng_kind != K_ADR
     && $past(need_rdy)) |-> $past(rdy_q));
  // R11: soft reset leaves config and timing cleared
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_fire) |-> (!cfg_ce && tim_q == '0 && !need_rdy));
endmodule

// File: tb/nandbus_seq_bench.sv
module nandbus_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_wait;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in = '0;
  logic        nand_rdy = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nandbus_seq u_nandbus_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rdy(nand_rdy));

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  int m_wait, m_pre, m_str, m_post, m_cle, m_ale, m_oe, m_iobad;
  logic [31:0] m_rdata;

  // vector table: kind 0=cmd 1=addr 2=data write 3=data read
  localparam int NV = 6;
  localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2};
  localparam logic [7:0]  V_BYTE [NV] = '{8'h70, 8'hA5, 8'h3C, 8'h5A, 8'hC3, 8'h81};
  localparam logic [31:0] V_TIM  [NV] = '{32'h0000_0000, 32'h1234_0000, 32'h0F1F_0000,
                                          32'h0000_4321, 32'hFFFF_0000, 32'h0000_FFFF};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [5:0] a, input logic [31:0] d,
                        input int rd_w, input logic [7:0] rbyte);
    int sidx;
    bit seen;
    m_wait = 0; m_pre = 0; m_str = 0; m_post = 0;
    m_cle = 0; m_ale = 0; m_oe = 0; m_iobad = 0;
    sidx = 0; seen = 1'b0;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = wr; reg_rd = !wr; nand_io_in = ~rbyte;
    #1;
    while (reg_wait && m_wait < 5000) begin
      @(negedge clk);
      if (reg_wait) begin
        m_wait++;
        if (!nand_we_n || !nand_re_n) begin
          m_str++; seen = 1'b1; sidx++;
          nand_io_in = (sidx == rd_w + 1) ? rbyte : ~rbyte;
        end else begin
          if (seen) m_post++; else m_pre++;
          nand_io_in = ~rbyte;
        end
        if (nand_cle) m_cle++;
        if (nand_ale) m_ale++;
        if (nand_io_oe) begin
          m_oe++;
          if (nand_io_out !== d[7:0]) m_iobad++;
        end
      end
    end
    m_rdata = reg_rdata;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  function automatic int fld(input logic [31:0] t, input bit rd, input int idx);
    int base;
    base = rd ? 0 : 16;
    return int'((t >> (base + 4*idx)) & 32'hF);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", 32'(nand_ce_n), 32'd1);
    chk("R1 cle/ale", 32'({nand_cle, nand_ale}), 32'd0);
    chk("R1 strobes", 32'({nand_we_n, nand_re_n}), 32'd3);
    chk("R1 oe", 32'(nand_io_oe), 32'd0);
    access(1'b0, 6'h2C, 32'h0, 0, 8'h0);
    chk("R1 timing reads 0", m_rdata, 32'h0);
    access(1'b0, 6'h14, 32'h0, 0, 8'h0);
    chk("R1 config reads 0", m_rdata, 32'h0);
    chk("R10 register read no stall", 32'(m_wait), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      bit rd;
      int s, w, h, dl, tot;
      rd = (V_KIND[i] == 2'd3);
      s = fld(V_TIM[i], rd, 0); h = fld(V_TIM[i], rd, 1);
      w = fld(V_TIM[i], rd, 2); dl = fld(V_TIM[i], rd, 3);
      tot = s + w + h + 3;
      access(1'b1, 6'h2C, V_TIM[i], 0, 8'h0);
      case (V_KIND[i])
        2'd0: access(1'b1, 6'h08, {24'h0, V_BYTE[i]}, 0, 8'h0);
        2'd1: access(1'b1, 6'h04, {24'h0, V_BYTE[i]}, 0, 8'h0);
        2'd2: access(1'b1, 6'h00, {24'hABCDEF, V_BYTE[i]}, 0, 8'h0);
        default: access(1'b0, 6'h00, 32'h0, w, V_BYTE[i]);
      endcase
      chk($sformatf("R5 setup v%0d", i), 32'(m_pre), 32'(s + 1));
      chk($sformatf("R5 width v%0d", i), 32'(m_str), 32'(w + 1));
      chk($sformatf("R6 hold+delay v%0d", i), 32'(m_post), 32'(h + 1 + 2*dl));
      chk($sformatf("R10 stall length v%0d", i), 32'(m_wait), 32'(tot + 2*dl));
      chk($sformatf("R2 cle v%0d", i), 32'(m_cle), (V_KIND[i] == 2'd0) ? 32'(tot) : 32'd0);
      chk($sformatf("R3 ale v%0d", i), 32'(m_ale), (V_KIND[i] == 2'd1) ? 32'(tot) : 32'd0);
      chk($sformatf("R4 oe v%0d", i), 32'(m_oe), rd ? 32'd0 : 32'(tot));
      chk($sformatf("R2 bus byte v%0d", i), 32'(m_iobad), 32'd0);
      if (rd) chk($sformatf("R4 read data v%0d", i), m_rdata, {24'h0, V_BYTE[i]});
    end

    // R7 chip enable control
    access(1'b1, 6'h2C, 32'h0, 0, 8'h0);
    access(1'b1, 6'h14, 32'h0000_0020, 0, 8'h0);
    chk("R7 ce low", 32'(nand_ce_n), 32'd0);
    access(1'b0, 6'h14, 32'h0, 0, 8'h0);
    chk("R7 readback", m_rdata, 32'h20);
    access(1'b1, 6'h14, 32'h0, 0, 8'h0);
    chk("R7 ce released", 32'(nand_ce_n), 32'd1);

    // R8 status mirrors ready
    nand_rdy = 1'b0;
    repeat (2) @(negedge clk);
    access(1'b0, 6'h18, 32'h0, 0, 8'h0);
    chk("R8 busy", m_rdata, 32'h0);
    nand_rdy = 1'b1;
    repeat (2) @(negedge clk);
    access(1'b0, 6'h18, 32'h0, 0, 8'h0);
    chk("R8 ready", m_rdata, 32'h1);

    // R9 data cycle held until ready after a command
    nand_rdy = 1'b0;
    access(1'b1, 6'h08, 32'h90, 0, 8'h0);
    begin
      int bad, str;
      bad = 0; str = 0;
      @(negedge clk);
      reg_addr = 6'h00; reg_wdata = 32'h11; reg_wr = 1'b1; reg_rd = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (!nand_we_n || !reg_wait) bad++;
      end
      chk("R9 no strobe while busy", 32'(bad), 32'd0);
      nand_rdy = 1'b1;
      while (reg_wait && str < 100) begin
        @(negedge clk);
        if (!nand_we_n) str++;
        if (reg_wait && nand_io_oe == 1'b0 && nand_we_n && str > 0) str = str;
      end
      chk("R9 one strobe after ready", 32'(str), 32'd1);
      @(posedge clk); #1;
      reg_wr = 1'b0;
    end

    // R11 soft reset
    nand_rdy = 1'b0;
    access(1'b1, 6'h08, 32'hFF, 0, 8'h0);
    access(1'b1, 6'h14, 32'h20, 0, 8'h0);
    access(1'b1, 6'h2C, 32'hFFFF_FFFF, 0, 8'h0);
    access(1'b1, 6'h10, 32'h4, 0, 8'h0);
    access(1'b0, 6'h2C, 32'h0, 0, 8'h0);
    chk("R11 timing cleared", m_rdata, 32'h0);
    access(1'b0, 6'h14, 32'h0, 0, 8'h0);
    chk("R11 config cleared", m_rdata, 32'h0);
    chk("R11 ce released", 32'(nand_ce_n), 32'd1);
    access(1'b1, 6'h00, 32'h22, 0, 8'h0);
    chk("R11 ready gate dropped", 32'(m_wait), 32'd3);
    chk("R11 strobe width", 32'(m_str), 32'd1);
    nand_rdy = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule